// File: doc/BRIEF.md
# Framebuffer Scan-Out Display Controller

This block drives a fixed-mode RGB panel of 640 by 480 visible pixels from a framebuffer held in system memory. Each pixel is one 32-bit word. The block generates the line and frame timing, then fetches the words for the coming frame in display order through a request/valid read port. It buffers them in a small prefetch FIFO and splits each word into 8-bit red, green and blue. Outside the visible area, and whenever the display is switched off, the colour outputs are held at zero.

Software programs the block through two registers. One holds the frame start address, of which only the top 11 bits are kept, so a frame always starts on a 2 MiB boundary. The other holds a display-enable bit and a 180-degree rotate bit. Rows sit a fixed 1024 words apart in memory, and only the first 640 words of each row are read. Rotation reverses the fetch order, so the last word of the last row is shown first. Register values are sampled once per frame, at the first line of vertical blanking. The sampled values then govern the next frame, and fetching for that frame starts at the same moment.

If the FIFO runs dry inside the visible area, the rest of that line is shown black and a sticky underflow flag is raised. The words owed to the missed pixels are discarded as they arrive, so later lines still show the right data. The reset input is asynchronous, active low, and is expected to be released in step with `clk`.

Top module: `pixscan_top`

## Requirements
- R1: While reset is held and right after it: `de` is low, `red`/`green`/`blue` are zero, `hsync_n` and `vsync_n` are high, `underflow` and `mem_req` are low, and both registers read as zero.
- R2: A write with `reg_off[2]`=0 loads the frame start register, which keeps only `reg_wdata[31:21]` and reads back with bits 20:0 zero. A write with `reg_off[2]`=1 loads the control register: bit 0 enables the display and bit 1 selects rotation. Other bits read back as zero. `reg_off[1:0]` is ignored.
- R3: A line lasts H_TOTAL clocks. `de` is high for the first H_ACT clocks of each of the first V_ACT lines. `hsync_n` is low for clocks H_SYNC_BEG to H_SYNC_END-1 of every line, and `vsync_n` is low for the whole of lines V_SYNC_BEG to V_SYNC_END-1. Both syncs are high while `de` is high. Each output reflects the timing count one clock earlier.
- R4: A displayed word is split as red = bits 23:16, green = bits 15:8 and blue = bits 7:0. Bits 31:24 have no effect.
- R5: Without rotation, the pixel at row r, column c comes from word address base/4 + r*2^STRIDE_LG + c. Exactly H_ACT*V_ACT words are requested per frame, and no requested column is H_ACT or above.
- R6: With rotation, the pixel at row r, column c comes from the word at row V_ACT-1-r, column H_ACT-1-c.
- R7: Whenever `de` is low, or the current frame was sampled with enable clear, the colour outputs are zero. `de` and the syncs keep running while the display is disabled.
- R8: Writes to either register do not change the frame being shown. The values present at the first clock of vertical blanking govern the whole next frame.
- R9: If a visible pixel finds no word ready, that pixel and the rest of its line are black and `underflow` goes high and stays high until reset. Later pixels still show the word belonging to them.
- R10: Words stored in the FIFO plus requests not yet answered never exceed FIFO_DEPTH. Once the FIFO is full, no further request is made until a pixel consumes a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 3 | Register byte offset; bit 2 selects control over frame start |
| reg_wdata | input | BUS_W | Register write data |
| reg_rdata | output | BUS_W | Read-back of the register chosen by `reg_off` |
| mem_req | output | 1 | Read request for one word |
| mem_addr | output | BUS_W-2 | Word address of the request |
| mem_ready | input | 1 | Memory accepts the request in this cycle |
| mem_rvalid | input | 1 | A requested word is returned (in request order) |
| mem_rdata | input | 32 | Returned word |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Visible-area data enable |
| red | output | 8 | Red level |
| green | output | 8 | Green level |
| blue | output | 8 | Blue level |
| underflow | output | 1 | Sticky flag: a visible pixel found the FIFO empty |

## Verification
The hardest case is a FIFO underflow recovery that overlaps with refill. In one cycle, a word may return from memory while an older word owed to a missed pixel is discarded, and the line may end at the same time. The bench provokes this by holding `mem_ready` low for twelve clocks early in the second visible row. In that frame, every pixel must be either black or exactly its own word, and once black appears it must stay black to the end of the line. The following frame must match pixel for pixel, with the flag still set. A second overlap is a register write landing near the frame sampling point. This is judged by showing one complete frame with the old settings and the next with the new.

// File: rtl/pixscan_pkg.sv
`timescale 1ns/1ps
package pixscan_pkg;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_ROT_BIT = 1;
  localparam int SEL_BIT      = 2;

  typedef struct packed {
    logic rot;
    logic en;
  } disp_ctrl_t;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  function automatic rgb_t split_word(input logic [31:0] w);
    rgb_t p;
    p.r = w[23:16];
    p.g = w[15:8];
    p.b = w[7:0];
    return p;
  endfunction

endpackage

// File: rtl/pixscan_regs.sv
`timescale 1ns/1ps
module pixscan_regs
  import pixscan_pkg::*;
#(
  parameter int BUS_W     = 32,
  parameter int BASE_BITS = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [2:0]           off,
  input  logic [BUS_W-1:0]     wdata,
  output logic [BASE_BITS-1:0] base_hi,
  output disp_ctrl_t           ctrl,
  output logic [BUS_W-1:0]     rdata
);
  localparam int LOW_BITS = BUS_W - BASE_BITS;

  logic [BASE_BITS-1:0] base_q, base_d;
  disp_ctrl_t           ctrl_q, ctrl_d;
  logic                 base_we, ctrl_we;

  assign base_we = wr && !off[SEL_BIT];
  assign ctrl_we = wr &&  off[SEL_BIT];

  always_comb begin
    base_d = base_q;
    ctrl_d = ctrl_q;
    if (base_we) base_d = wdata[BUS_W-1 -: BASE_BITS];
    if (ctrl_we) begin
      ctrl_d.en  = wdata[CTRL_EN_BIT];
      ctrl_d.rot = wdata[CTRL_ROT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (base_we) base_q <= base_d;
      if (ctrl_we) ctrl_q <= ctrl_d;
    end
  end

  assign base_hi = base_q;
  assign ctrl    = ctrl_q;
  assign rdata   = off[SEL_BIT] ? {{(BUS_W-2){1'b0}}, ctrl_q}
                                : {base_q, {LOW_BITS{1'b0}}};

  logic unused_bits;
  assign unused_bits = ^{off[1:0], wdata[LOW_BITS-1:2]};

endmodule

// File: rtl/pixscan_timing.sv
`timescale 1ns/1ps
module pixscan_timing #(
  parameter int H_ACT      = 640,
  parameter int H_SYNC_BEG = 656,
  parameter int H_SYNC_END = 752,
  parameter int H_TOTAL    = 800,
  parameter int V_ACT      = 480,
  parameter int V_SYNC_BEG = 490,
  parameter int V_SYNC_END = 492,
  parameter int V_TOTAL    = 525
) (
  input  logic clk,
  input  logic rst_n,
  output logic act,
  output logic hs_on,
  output logic vs_on,
  output logic line_end,
  output logic restart
);
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;

  always_comb begin
    h_d = line_end ? '0 : h_q + 1'b1;
    v_d = v_q;
    if (line_end) v_d = (v_q == V_LAST) ? '0 : v_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign line_end = (h_q == H_LAST);
  assign restart  = line_end && (v_q == VW'(V_ACT - 1));
  assign act      = (h_q < HW'(H_ACT)) && (v_q < VW'(V_ACT));
  assign hs_on    = (h_q >= HW'(H_SYNC_BEG)) && (h_q < HW'(H_SYNC_END));
  assign vs_on    = (v_q >= VW'(V_SYNC_BEG)) && (v_q < VW'(V_SYNC_END));

endmodule

// File: rtl/pixscan_fetch.sv
`timescale 1ns/1ps
module pixscan_fetch #(
  parameter int AW        = 30,
  parameter int BASE_BITS = 11,
  parameter int STRIDE_LG = 10,
  parameter int H_ACT     = 640,
  parameter int V_ACT     = 480,
  parameter int DEPTH     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic                       run,
  input  logic                       rot,
  input  logic [BASE_BITS-1:0]       base_hi,
  output logic                       mem_req,
  output logic [AW-1:0]              mem_addr,
  input  logic                       mem_ready,
  input  logic                       mem_rvalid,
  input  logic [31:0]                mem_rdata,
  input  logic                       pop,
  output logic [31:0]                head,
  output logic                       empty,
  output logic [$clog2(DEPTH+1):0]   occ
);
  localparam int CW = $clog2(H_ACT);
  localparam int RW = $clog2(V_ACT + 1);
  localparam int PW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);
  localparam int OW = NW + 1;

  logic [CW-1:0] col_q, col_d, pcol;
  logic [RW-1:0] row_q, row_d, prow;
  logic [NW-1:0] infl_q, infl_d, drop_q, drop_d, cnt_q, cnt_d;
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [31:0]   store_q [DEPTH];
  logic          acc, push, done;

  assign prow     = rot ? RW'(V_ACT - 1) - row_q : row_q;
  assign pcol     = rot ? CW'(H_ACT - 1) - col_q : col_q;
  assign mem_addr = {base_hi, {(AW-BASE_BITS){1'b0}}}
                  + ((AW'(prow) << STRIDE_LG) | AW'(pcol));

  assign occ     = {1'b0, cnt_q} + {1'b0, infl_q};
  assign done    = (row_q == RW'(V_ACT));
  assign mem_req = run && !done && !restart && (occ < OW'(DEPTH));
  assign acc     = mem_req && mem_ready;
  assign push    = mem_rvalid && (drop_q == '0) && !restart;

  always_comb begin
    col_d  = col_q;
    row_d  = row_q;
    if (restart) begin
      col_d = '0;
      row_d = '0;
    end else if (acc) begin
      if (col_q == CW'(H_ACT - 1)) begin
        col_d = '0;
        row_d = row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
    infl_d = infl_q + NW'(acc) - NW'(mem_rvalid);
    drop_d = restart ? infl_d : drop_q - NW'(mem_rvalid && (drop_q != '0));
    wp_d   = restart ? '0 : (push ? ((wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1) : wp_q);
    rp_d   = restart ? '0 : (pop  ? ((rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1) : rp_q);
    cnt_d  = restart ? '0 : cnt_q + NW'(push) - NW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= RW'(V_ACT);
      infl_q <= '0;
      drop_q <= '0;
      cnt_q  <= '0;
      wp_q   <= '0;
      rp_q   <= '0;
    end else begin
      col_q  <= col_d;
      row_q  <= row_d;
      infl_q <= infl_d;
      drop_q <= drop_d;
      cnt_q  <= cnt_d;
      wp_q   <= wp_d;
      rp_q   <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store_q[wp_q] <= mem_rdata;
  end

  assign head  = store_q[rp_q];
  assign empty = (cnt_q == '0);

endmodule

// File: rtl/pixscan_top.sv
`timescale 1ns/1ps
module pixscan_top
  import pixscan_pkg::*;
#(
  parameter int BUS_W      = 32,
  parameter int BASE_BITS  = 11,
  parameter int STRIDE_LG  = 10,
  parameter int H_ACT      = 640,
  parameter int H_SYNC_BEG = 656,
  parameter int H_SYNC_END = 752,
  parameter int H_TOTAL    = 800,
  parameter int V_ACT      = 480,
  parameter int V_SYNC_BEG = 490,
  parameter int V_SYNC_END = 492,
  parameter int V_TOTAL    = 525,
  parameter int FIFO_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_off,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  output logic             mem_req,
  output logic [BUS_W-3:0] mem_addr,
  input  logic             mem_ready,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             de,
  output logic [7:0]       red,
  output logic [7:0]       green,
  output logic [7:0]       blue,
  output logic             underflow
);
  localparam int AW  = BUS_W - 2;
  localparam int OWW = $clog2(H_ACT * V_ACT + 1);

  logic [BASE_BITS-1:0] base_live, frame_base_q;
  disp_ctrl_t           ctrl_live, frame_q;
  logic                 act, hs_on, vs_on, line_end, restart;
  logic                 pop, empty, serve, discard, miss;
  logic [31:0]          head;
  logic [$clog2(FIFO_DEPTH+1):0] fill_occ;
  logic [OWW-1:0]       owed_q, owed_d;
  logic                 dead_q, dead_d, uf_q, uf_d;
  logic                 de_q, hs_q, vs_q;
  rgb_t                 pix_q, pix_d;

  pixscan_regs #(.BUS_W(BUS_W), .BASE_BITS(BASE_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .off(reg_off), .wdata(reg_wdata),
    .base_hi(base_live), .ctrl(ctrl_live), .rdata(reg_rdata)
  );

  pixscan_timing #(
    .H_ACT(H_ACT), .H_SYNC_BEG(H_SYNC_BEG), .H_SYNC_END(H_SYNC_END), .H_TOTAL(H_TOTAL),
    .V_ACT(V_ACT), .V_SYNC_BEG(V_SYNC_BEG), .V_SYNC_END(V_SYNC_END), .V_TOTAL(V_TOTAL)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .act(act), .hs_on(hs_on), .vs_on(vs_on),
    .line_end(line_end), .restart(restart)
  );

  pixscan_fetch #(
    .AW(AW), .BASE_BITS(BASE_BITS), .STRIDE_LG(STRIDE_LG),
    .H_ACT(H_ACT), .V_ACT(V_ACT), .DEPTH(FIFO_DEPTH)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(frame_q.en), .rot(frame_q.rot),
    .base_hi(frame_base_q), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .pop(pop), .head(head), .empty(empty), .occ(fill_occ)
  );

  // pixel slot service, owed-word accounting and line kill
  always_comb begin
    serve   = frame_q.en && act && !dead_q && (owed_q == '0) && !empty;
    miss    = frame_q.en && act && !serve;
    discard = !empty && (owed_q != '0);
    pop     = serve || discard;
    owed_d  = restart ? '0 : owed_q + OWW'(miss) - OWW'(discard);
    dead_d  = (restart || line_end) ? 1'b0 : (dead_q || miss);
    uf_d    = uf_q || miss;
    pix_d   = serve ? split_word(head) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q      <= '0;
      frame_base_q <= '0;
      owed_q       <= '0;
      dead_q       <= 1'b0;
      uf_q         <= 1'b0;
      de_q         <= 1'b0;
      hs_q         <= 1'b1;
      vs_q         <= 1'b1;
      pix_q        <= '0;
    end else begin
      if (restart) begin
        frame_q      <= ctrl_live;
        frame_base_q <= base_live;
      end
      owed_q <= owed_d;
      dead_q <= dead_d;
      uf_q   <= uf_d;
      de_q   <= act;
      hs_q   <= !hs_on;
      vs_q   <= !vs_on;
      pix_q  <= pix_d;
    end
  end

  assign de        = de_q;
  assign hsync_n   = hs_q;
  assign vsync_n   = vs_q;
  assign red       = pix_q.r;
  assign green     = pix_q.g;
  assign blue      = pix_q.b;
  assign underflow = uf_q;

endmodule

// File: rtl/pixscan_chk.sv
`timescale 1ns/1ps
module pixscan_chk #(
  parameter int AW        = 30,
  parameter int BASE_BITS = 11,
  parameter int STRIDE_LG = 10,
  parameter int H_ACT     = 640,
  parameter int DEPTH     = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     de,
  input logic                     hsync_n,
  input logic                     vsync_n,
  input logic [7:0]               red,
  input logic [7:0]               green,
  input logic [7:0]               blue,
  input logic                     underflow,
  input logic                     mem_req,
  input logic [AW-1:0]            mem_addr,
  input logic [$clog2(DEPTH+1):0] occ,
  input logic                     restart,
  input logic [1:0]               frame_ctrl,
  input logic [BASE_BITS-1:0]     frame_base
);
  // R3: syncs are idle throughout the visible area
  a_r3_sync_idle_in_active: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync_n && vsync_n));

  // R7: no colour outside the visible area
  a_r7_black_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> ({red, green, blue} == 24'd0));

  // R9: underflow flag is sticky
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  // R10: stored plus outstanding words never exceed the FIFO
  a_r10_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= ($clog2(DEPTH+1)+1)'(DEPTH));

  // R5: never request a column beyond the visible width
  a_r5_col_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[STRIDE_LG-1:0] < STRIDE_LG'(H_ACT)));

  // R8: frame settings only move at the sampling point
  a_r8_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable({frame_ctrl, frame_base}));

endmodule

bind pixscan_top pixscan_chk #(
  .AW(AW), .BASE_BITS(BASE_BITS), .STRIDE_LG(STRIDE_LG), .H_ACT(H_ACT), .DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .de(de), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .red(red), .green(green), .blue(blue), .underflow(underflow),
  .mem_req(mem_req), .mem_addr(mem_addr), .occ(fill_occ), .restart(restart),
  .frame_ctrl(frame_q), .frame_base(frame_base_q)
);

// File: tb/pixscan_top_tb.sv
`timescale 1ns/1ps
module pixscan_top_tb_top;
  localparam int HA = 8, HT = 16, HSB = 10, HSE = 12;
  localparam int VA = 4, VT = 8, VSB = 5, VSE = 6;
  localparam int SLG = 4, DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_off = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [29:0] mem_addr;
  logic        mem_ready, mem_rvalid;
  logic [31:0] mem_rdata;
  logic        hsync_n, vsync_n, de, underflow;
  logic [7:0]  red, green, blue;

  bit          stall = 1'b0;
  bit          p1v, p2v;
  logic [31:0] p1d, p2d;
  int          acc_cnt = 0;
  int          n_checks = 0, n_err = 0;

  always #10 clk = ~clk;

  pixscan_top #(
    .STRIDE_LG(SLG), .H_ACT(HA), .H_SYNC_BEG(HSB), .H_SYNC_END(HSE), .H_TOTAL(HT),
    .V_ACT(VA), .V_SYNC_BEG(VSB), .V_SYNC_END(VSE), .V_TOTAL(VT), .FIFO_DEPTH(DEPTH)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .de(de), .red(red), .green(green), .blue(blue), .underflow(underflow)
  );

  function automatic logic [31:0] mdata(input logic [29:0] a);
    return {8'hC3, a[7:0], a[7:0] ^ 8'h5A, a[15:8] ^ a[27:20]};
  endfunction

  // memory model: two-cycle, in-order
  assign mem_ready  = !stall;
  assign mem_rvalid = p2v;
  assign mem_rdata  = p2d;
  always @(posedge clk) begin
    p1v <= mem_req && mem_ready;
    p1d <= mdata(mem_addr);
    p2v <= p1v;
    p2d <= p1d;
    if (mem_req && mem_ready) acc_cnt <= acc_cnt + 1;
  end

  // stimulus table: written frame start, control word, expected word base
  localparam logic [31:0] T_BASE [4]  = '{32'h0020_0000, 32'h005F_FFFC, 32'hFFE0_0010, 32'h00A0_0000};
  localparam logic [31:0] T_CTRL [4]  = '{32'h0000_0001, 32'h0000_0003, 32'hFFFF_FFFD, 32'h0000_0002};
  localparam logic [29:0] T_WBASE [4] = '{30'h0008_0000, 30'h0010_0000, 30'h3FF8_0000, 30'h0028_0000};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = off; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_vs();
    while (vsync_n == 1'b0) @(negedge clk);
    while (vsync_n == 1'b1) @(negedge clk);
  endtask

  // check one frame from the current vsync to the next vsync
  task automatic check_frame(input logic [29:0] wb, input bit en, input bit rot, input bit allow,
                             output int blacks, output int pix, output int bad,
                             output logic [23:0] g1, output logic [23:0] e1);
    int row = 0, col = 0;
    bit prev = 0, dead = 0;
    logic [29:0] a;
    logic [23:0] exp, got;
    blacks = 0; pix = 0; bad = 0; g1 = '0; e1 = '0;
    while (vsync_n == 1'b0) @(negedge clk);
    while (vsync_n == 1'b1) begin
      got = {red, green, blue};
      if (de) begin
        a   = wb + 30'((rot ? VA-1-row : row) * (1 << SLG)) + 30'(rot ? HA-1-col : col);
        exp = en ? mdata(a)[23:0] : 24'd0;
        if (allow && got == 24'd0) begin
          dead = 1; blacks++;
        end else if (dead || got != exp) begin
          if (bad == 0) begin g1 = got; e1 = exp; end
          bad++;
        end
        col++; pix++;
      end else begin
        if (got != 24'd0) begin
          if (bad == 0) begin g1 = got; e1 = 24'd0; end
          bad++;
        end
        if (prev) begin row++; col = 0; dead = 0; end
      end
      prev = de;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin : main
    int blk, px, bad, t0, t1;
    logic [23:0] g1, e1;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(de == 0 && {red, green, blue} == 0, "R1", "de/rgb in reset", {de, red, green, blue}, 0);
    check(hsync_n && vsync_n && !underflow && !mem_req, "R1", "syncs/flag/req in reset",
          {hsync_n, vsync_n, underflow, mem_req}, 4'b1100);
    reg_off = 3'd0; #1;
    check(reg_rdata == 0, "R1", "base reg after reset", reg_rdata, 0);
    reg_off = 3'd4; #1;
    check(reg_rdata == 0, "R1", "ctrl reg after reset", reg_rdata, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: register decode and read-back
    wr_reg(3'd1, 32'h1234_5678);
    reg_off = 3'd2; #1;
    check(reg_rdata == 32'h1220_0000, "R2", "base keeps bits 31:21", reg_rdata, 32'h1220_0000);
    wr_reg(3'd7, 32'hFFFF_FFFF);
    reg_off = 3'd4; #1;
    check(reg_rdata == 32'h3, "R2", "ctrl keeps bits 1:0", reg_rdata, 32'h3);
    wr_reg(3'd4, 32'h0);

    // R3: timing
    while (hsync_n) @(negedge clk);
    t0 = 0; while (!hsync_n) begin t0++; @(negedge clk); end
    check(t0 == HSE - HSB, "R3", "hsync low width", t0, HSE - HSB);
    t1 = t0; while (hsync_n) begin t1++; @(negedge clk); end
    check(t1 == HT, "R3", "line period", t1, HT);
    while (!de) @(negedge clk);
    t0 = 0; while (de) begin t0++; @(negedge clk); end
    check(t0 == HA, "R3", "de run length", t0, HA);
    t1 = 0; while (hsync_n) begin t1++; @(negedge clk); end
    check(t1 == HSB - HA, "R3", "de fall to hsync", t1, HSB - HA);
    wait_vs();
    t0 = 0; while (!vsync_n) begin t0++; @(negedge clk); end
    check(t0 == (VSE - VSB) * HT, "R3", "vsync low width", t0, (VSE - VSB) * HT);

    // table: R4 R5 R6 R7 (entry 1 also R2 low bits ignored)
    for (int i = 0; i < 4; i++) begin
      wr_reg(3'd0, T_BASE[i]);
      wr_reg(3'd4, T_CTRL[i]);
      wait_vs(); wait_vs();
      check_frame(T_WBASE[i], T_CTRL[i][0], T_CTRL[i][1], 0, blk, px, bad, g1, e1);
      check(bad == 0, "R4 R5 R6 R7", $sformatf("table entry %0d pixels", i), g1, e1);
      check(px == HA * VA, "R3", $sformatf("table entry %0d pixel count", i), px, HA * VA);
    end

    // R10 and R5: request count and no request beyond FIFO room
    wr_reg(3'd0, 32'h0020_0000);
    wr_reg(3'd4, 32'h1);
    wait_vs(); wait_vs();
    t0 = acc_cnt;
    while (!de) @(negedge clk);
    check(acc_cnt == t0, "R10", "requests while FIFO full", acc_cnt - t0, 0);
    wait_vs();
    check(acc_cnt - t0 == HA * VA, "R5", "words requested per frame", acc_cnt - t0, HA * VA);

    // R8: change mid-stream, current frame keeps old settings
    wr_reg(3'd4, 32'h3);
    check_frame(30'h0008_0000, 1, 0, 0, blk, px, bad, g1, e1);
    check(bad == 0, "R8", "frame after write keeps old order", g1, e1);
    check_frame(30'h0008_0000, 1, 1, 0, blk, px, bad, g1, e1);
    check(bad == 0, "R8", "following frame rotated", g1, e1);
    wr_reg(3'd4, 32'h1);
    wait_vs(); wait_vs();

    // R9: underflow
    check(underflow == 0, "R9", "flag clear before stall", underflow, 0);
    fork
      check_frame(30'h0008_0000, 1, 0, 1, blk, px, bad, g1, e1);
      begin
        while (!de) @(negedge clk);
        while (de) @(negedge clk);
        while (!de) @(negedge clk);
        repeat (2) @(negedge clk);
        stall = 1'b1;
        repeat (12) @(negedge clk);
        stall = 1'b0;
      end
    join
    check(bad == 0, "R9", "no wrong pixel, black to line end", g1, e1);
    check(blk > 0, "R9", "black pixels on stall", blk, 1);
    check(underflow == 1, "R9", "flag set", underflow, 1);
    check_frame(30'h0008_0000, 1, 0, 0, blk, px, bad, g1, e1);
    check(bad == 0, "R9", "next frame realigned", g1, e1);
    check(underflow == 1, "R9", "flag sticky", underflow, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule